// File: doc/BRIEF.md
# Instruction Exception Detection Sequencer

This block sits between the decode and execute stages of a small processor core. Each cycle it inspects the class code of the decoded instruction together with the live status register. It decides whether the instruction may execute or must be turned into an exception. An illegal opcode, an unimplemented opcode or a supervisor-only operation attempted in user mode is stopped before it runs. The execute enable stays low in that cycle, so no data or address register can change. A trace exception is instead taken after an ordinary instruction has executed, when the trace field of the status register asks for one.

Once an exception is taken, the block writes a new status register value with supervisor mode set and tracing cleared. It then performs four 16-bit writes down the supervisor stack through a simple request/ready handshake. The writes carry the status register as it was before entry, the high and low halves of the saved program counter, and the vector offset. A one-cycle done pulse carrying the vector number closes the sequence. New decode inputs are ignored until that sequence has finished.

Top module: `exc_seq`

## Requirements
- R1: Instruction classes are 5-bit codes: 0 plain, 1 flow change, 2 illegal, 3 and 4 unimplemented, 5 to 16 supervisor-only. Class 2, and any code from 17 to 31, raises an exception with vector number 4.
- R2: Class 3 raises vector 10 and class 4 raises vector 11, regardless of mode or trace bits.
- R3: A supervisor-only class (5 to 16) with status bit 13 (supervisor) clear raises vector 8. With bit 13 set, the instruction executes.
- R4: In the decode cycle of an accepted instruction, `exec_en` is high exactly when no exception is raised before execution. A faulting instruction never sees `exec_en` high.
- R5: Precedence is illegal/unimplemented, then privilege violation, then trace. A faulting instruction never produces a trace exception.
- R6: Status bits 15:14 form the trace field. 00 disables tracing. Bit 15 set traces every instruction. 01 traces only class 1. Trace uses vector 9, is taken in the cycle after `exec_en`, and stacks `dec_next_pc`.
- R7: For vectors 4, 8, 10 and 11 the stacked PC equals `dec_pc`, the address of the offending instruction.
- R8: On exception entry, `sr_we` pulses for one cycle and `sr_wdata` equals `sr_in` with bit 13 set and bits 15:14 cleared. For a fault this happens in the decode cycle; for a trace it happens in the cycle after execution.
- R9: Stack writes occur in this order: the status register sampled at entry, PC bits 31:16, PC bits 15:0, then the vector number times 4.
- R10: Write k (k = 1..4) goes to `ssp_in` minus 2k. Each write holds its address and data while `mem_rdy` is low.
- R11: One cycle after the fourth write is acknowledged, `done` is high for exactly one cycle with `done_vec` equal to the vector number.
- R12: From exception entry until `done`, `dec_ready` is low and `dec_valid` has no effect: `exec_en` and `sr_we` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_valid | input | 1 | Decoded instruction present |
| dec_class | input | 5 | Instruction class code |
| dec_pc | input | 32 | Address of the instruction's first word |
| dec_next_pc | input | 32 | Address of the following instruction |
| sr_in | input | 16 | Live status register |
| ssp_in | input | 32 | Supervisor stack pointer at entry |
| mem_rdy | input | 1 | Acknowledge for the current stack write |
| dec_ready | output | 1 | Decode input is accepted this cycle |
| exec_en | output | 1 | Instruction may execute and write registers |
| sr_we | output | 1 | Status register write strobe |
| sr_wdata | output | 16 | New status register value |
| mem_req | output | 1 | Stack write request |
| mem_addr | output | 32 | Stack write address |
| mem_wdata | output | 16 | Stack write data |
| done | output | 1 | Exception sequence finished |
| done_vec | output | 8 | Vector number of the finished exception |

## Verification
The fault decision, `exec_en` and the entry `sr_we` are combinational on the decode inputs. The bench therefore samples them 1 ns after driving at the falling edge, inside the same cycle. A trace entry's `sr_we` is due one cycle after the decode cycle. The first stack write is presented in the cycle after entry, and each later write follows the rising edge on which `mem_rdy` was high. The bench checks every write in the cycle of its acknowledge, after a varying number of stall cycles. `done` is checked exactly one cycle after the last acknowledge. The sweep covers all 32 class codes under both modes and all four trace settings.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  localparam int CLS_W = 5;
  localparam int SR_W  = 16;
  localparam int VEC_W = 8;

  localparam int SR_SUP = 13;
  localparam int SR_TLO = 14;
  localparam int SR_THI = 15;

  typedef enum logic [CLS_W-1:0] {
    C_PLAIN      = 5'd0,
    C_FLOW       = 5'd1,
    C_ILLEGAL    = 5'd2,
    C_UNIMP_A    = 5'd3,
    C_UNIMP_B    = 5'd4,
    C_ANDI_SR    = 5'd5,
    C_EORI_SR    = 5'd6,
    C_ORI_SR     = 5'd7,
    C_LOWPWR     = 5'd8,
    C_SR_READ    = 5'd9,
    C_SR_WRITE   = 5'd10,
    C_USP_MOVE   = 5'd11,
    C_CTRL_MOVE  = 5'd12,
    C_SPACE_MOVE = 5'd13,
    C_BUS_RESET  = 5'd14,
    C_EXC_RETURN = 5'd15,
    C_HALT       = 5'd16
  } iclass_e;

  localparam logic [VEC_W-1:0] VEC_ILLEGAL = 8'd4;
  localparam logic [VEC_W-1:0] VEC_PRIV    = 8'd8;
  localparam logic [VEC_W-1:0] VEC_TRACE   = 8'd9;
  localparam logic [VEC_W-1:0] VEC_EMU_A   = 8'd10;
  localparam logic [VEC_W-1:0] VEC_EMU_B   = 8'd11;

  // supervisor-only classes occupy a contiguous code range
  function automatic logic is_privileged(input logic [CLS_W-1:0] c);
    return (c >= C_ANDI_SR) && (c <= C_HALT);
  endfunction

  function automatic logic is_known(input logic [CLS_W-1:0] c);
    return c <= C_HALT;
  endfunction

  // stacked offset is four bytes per vector table slot
  function automatic logic [SR_W-1:0] vec_offset(input logic [VEC_W-1:0] v);
    return SR_W'(v) << 2;
  endfunction

  // entry value: supervisor on, trace field cleared
  function automatic logic [SR_W-1:0] enter_sr(input logic [SR_W-1:0] sr);
    logic [SR_W-1:0] r;
    r = sr;
    r[SR_SUP] = 1'b1;
    r[SR_TLO] = 1'b0;
    r[SR_THI] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_seq_pkg::*;
(
  input  logic [CLS_W-1:0] cls,
  input  logic [SR_W-1:0]  sr,
  output logic             fault,
  output logic [VEC_W-1:0] fault_vec,
  output logic             trace_req
);
  always_comb begin
    fault     = 1'b1;
    fault_vec = VEC_ILLEGAL;
    if (cls == C_UNIMP_A)
      fault_vec = VEC_EMU_A;
    else if (cls == C_UNIMP_B)
      fault_vec = VEC_EMU_B;
    else if (!is_known(cls) || cls == C_ILLEGAL)
      fault_vec = VEC_ILLEGAL;
    else if (is_privileged(cls) && !sr[SR_SUP])
      fault_vec = VEC_PRIV;
    else
      fault = 1'b0;
  end

  // trace only for instructions that actually run
  assign trace_req = !fault && (sr[SR_THI] || (sr[SR_TLO] && cls == C_FLOW));
endmodule

// File: rtl/exc_stacker.sv
module exc_stacker
  import exc_seq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    sp_init,
  input  logic [SR_W-1:0]  sr_old,
  input  logic [AW-1:0]    pc,
  input  logic [VEC_W-1:0] vec,
  input  logic             mem_rdy,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  output logic [SR_W-1:0]  mem_wdata,
  output logic             last_ack,
  output logic             done,
  output logic [VEC_W-1:0] done_vec
);
  localparam int PC_WORDS = AW / SR_W;
  localparam int NWR      = PC_WORDS + 2;
  localparam int IDX_W    = $clog2(NWR);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NWR - 1);
  localparam logic [AW-1:0]    STEP = AW'(SR_W / 8);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic [AW-1:0]    sp_q;
  logic [SR_W-1:0]  sr_q;
  logic [AW-1:0]    pc_q;
  logic [VEC_W-1:0] vec_q;

  assign mem_req  = busy_q;
  assign mem_addr = sp_q - STEP;
  assign last_ack = busy_q && mem_rdy && (idx_q == LAST);

  always_comb begin
    if (idx_q == '0)
      mem_wdata = sr_q;
    else if (idx_q == LAST)
      mem_wdata = vec_offset(vec_q);
    else
      mem_wdata = SR_W'(pc_q >> (SR_W * (PC_WORDS - int'(idx_q))));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      idx_q    <= '0;
      sp_q     <= '0;
      sr_q     <= '0;
      pc_q     <= '0;
      vec_q    <= '0;
      done     <= 1'b0;
      done_vec <= '0;
    end else begin
      done <= last_ack;
      if (last_ack) done_vec <= vec_q;
      if (start) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        sp_q   <= sp_init;
        sr_q   <= sr_old;
        pc_q   <= pc;
        vec_q  <= vec;
      end else if (busy_q && mem_rdy) begin
        sp_q <= sp_q - STEP;
        if (idx_q == LAST) busy_q <= 1'b0;
        else idx_q <= idx_q + 1'b1;
      end
    end
  end

  assert_sp_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_rdy && !last_ack) |=> (mem_req && mem_addr == $past(mem_addr) - STEP));

  assert_hold_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_offset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(mem_wdata) == vec_offset(done_vec) && $past(mem_rdy)));
endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_seq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid,
  input  logic [CLS_W-1:0] dec_class,
  input  logic [AW-1:0]    dec_pc,
  input  logic [AW-1:0]    dec_next_pc,
  input  logic [SR_W-1:0]  sr_in,
  input  logic [AW-1:0]    ssp_in,
  input  logic             mem_rdy,
  output logic             dec_ready,
  output logic             exec_en,
  output logic             sr_we,
  output logic [SR_W-1:0]  sr_wdata,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  output logic [SR_W-1:0]  mem_wdata,
  output logic             done,
  output logic [VEC_W-1:0] done_vec
);
  typedef enum logic [1:0] {S_IDLE, S_TENTER, S_STACK} st_e;

  st_e              state_q;
  logic [AW-1:0]    trace_pc_q;
  logic             fault, trace_req, accept;
  logic             start_fault, start_trace, last_ack;
  logic [VEC_W-1:0] fault_vec, stk_vec;
  logic [AW-1:0]    stk_pc;

  exc_classify u_cls (
    .cls(dec_class), .sr(sr_in),
    .fault(fault), .fault_vec(fault_vec), .trace_req(trace_req)
  );

  assign dec_ready   = (state_q == S_IDLE);
  assign accept      = dec_valid && dec_ready;
  assign exec_en     = accept && !fault;
  assign start_fault = accept && fault;
  assign start_trace = (state_q == S_TENTER);
  assign sr_we       = start_fault || start_trace;
  assign sr_wdata    = enter_sr(sr_in);
  assign stk_pc      = start_trace ? trace_pc_q : dec_pc;
  assign stk_vec     = start_trace ? VEC_TRACE : fault_vec;

  exc_stacker #(.AW(AW)) u_stk (
    .clk(clk), .rst_n(rst_n), .start(sr_we), .sp_init(ssp_in),
    .sr_old(sr_in), .pc(stk_pc), .vec(stk_vec), .mem_rdy(mem_rdy),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .last_ack(last_ack), .done(done), .done_vec(done_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      trace_pc_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (start_fault) state_q <= S_STACK;
          else if (exec_en && trace_req) begin
            state_q    <= S_TENTER;
            trace_pc_q <= dec_next_pc;
          end
        end
        S_TENTER: state_q <= S_STACK;
        S_STACK:  if (last_ack) state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  assert_no_exec_while_stacking_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (!exec_en && !sr_we));

  assert_priv_vector_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_privileged(dec_class) && !sr_in[SR_SUP]) |-> (sr_we && stk_vec == VEC_PRIV));

  assert_sr_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sr_we |-> (sr_wdata[SR_SUP] && !sr_wdata[SR_THI] && !sr_wdata[SR_TLO]));

  assert_trace_after_exec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_trace |-> $past(exec_en));

  assert_stack_follows_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sr_we |=> (mem_req && mem_addr == $past(ssp_in) - AW'(2) && mem_wdata == $past(sr_in)));
endmodule

// File: tb/exc_seq_bench.sv
module exc_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dec_valid = 1'b0;
  logic [4:0]  dec_class = '0;
  logic [31:0] dec_pc = '0, dec_next_pc = '0, ssp_in = '0;
  logic [15:0] sr_in = '0;
  logic        mem_rdy = 1'b0;
  logic        dec_ready, exec_en, sr_we, mem_req, done;
  logic [15:0] sr_wdata, mem_wdata;
  logic [31:0] mem_addr;
  logic [7:0]  done_vec;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  exc_seq u_exc_seq (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_class(dec_class),
    .dec_pc(dec_pc), .dec_next_pc(dec_next_pc), .sr_in(sr_in), .ssp_in(ssp_in),
    .mem_rdy(mem_rdy), .dec_ready(dec_ready), .exec_en(exec_en), .sr_we(sr_we),
    .sr_wdata(sr_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .done(done), .done_vec(done_vec)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected vector before execution, 0 when the instruction runs
  function automatic int pre_vec(input int cls, input bit sup);
    if (cls == 3) return 10;
    if (cls == 4) return 11;
    if (cls == 2 || cls > 16) return 4;
    if (cls >= 5 && cls <= 16 && !sup) return 8;
    return 0;
  endfunction

  function automatic logic [15:0] entry_sr(input logic [15:0] s);
    return (s | 16'h2000) & 16'h3fff;
  endfunction

  task automatic run_case(input int cls, input bit sup, input logic [1:0] tf, input int n);
    int vec;
    bit trc;
    logic [15:0] sr0;
    logic [31:0] pc, sp, spc;
    logic [15:0] words [4];
    vec = pre_vec(cls, sup);
    trc = (vec == 0) && (tf[1] || (tf[0] && cls == 1));
    sr0 = {tf, sup, 13'(n * 37 + 5)};
    pc  = 32'h0003_0000 + 32'(n * 6);
    sp  = 32'h0000_8000 + 32'(n * 16);
    @(negedge clk);
    dec_valid = 1'b1; dec_class = 5'(cls); dec_pc = pc; dec_next_pc = pc + 2;
    sr_in = sr0; ssp_in = sp;
    #1;
    chk("R12 ready when idle", dec_ready, 1);
    if (vec != 0) begin
      chk("R1/R2/R3 fault blocks exec R4", exec_en, 0);
      chk("R8 entry strobe", sr_we, 1);
      chk("R8 entry value", sr_wdata, entry_sr(sr0));
    end else begin
      chk("R4 exec allowed", exec_en, 1);
      chk("R5 no entry strobe", sr_we, 0);
    end
    @(negedge clk);
    if (vec == 0 && !trc) begin
      dec_valid = 1'b0;
      #1;
      chk("R6 no trace request", mem_req, 0);
      chk("R6 no trace strobe", sr_we, 0);
      return;
    end
    dec_class = 5'd0; // plain instruction, must be ignored
    if (trc) begin
      #1;
      chk("R6 trace strobe one cycle after exec", sr_we, 1);
      chk("R8 trace entry value", sr_wdata, entry_sr(sr0));
      chk("R12 ignored in trace entry", exec_en, 0);
      vec = 9;
      spc = pc + 2;
      @(negedge clk);
    end else spc = pc;
    words[0] = sr0; words[1] = spc[31:16]; words[2] = spc[15:0]; words[3] = 16'(vec * 4);
    for (int k = 0; k < 4; k++) begin
      for (int w = 0; w < (n + k) % 3; w++) begin
        #1;
        chk("R10 request held", mem_req, 1);
        chk("R12 ignored while stacking", exec_en, 0);
        chk("R12 not ready", dec_ready, 0);
        @(negedge clk);
      end
      mem_rdy = 1'b1;
      #1;
      chk("R10 address", mem_addr, sp - 32'(2 * (k + 1)));
      chk(k == 0 ? "R9 word SR" : (k == 3 ? "R9 word offset" : "R7 word PC"), mem_wdata, words[k]);
      chk("R12 no strobe", sr_we, 0);
      @(negedge clk);
      mem_rdy = 1'b0;
    end
    dec_valid = 1'b0;
    #1;
    chk("R11 done pulse", done, 1);
    chk("R11 done vector", done_vec, vec);
    @(negedge clk);
    #1;
    chk("R11 done single cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("reset ready", dec_ready, 1);
    chk("reset no request", mem_req, 0);
    chk("reset no done", done, 0);
    chk("reset no strobe", sr_we, 0);
    rst_n = 1'b1;
    for (int c = 0; c < 32; c++)
      for (int s = 0; s < 2; s++)
        for (int t = 0; t < 4; t++)
          run_case(c, s[0], t[1:0], c * 8 + s * 4 + t);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule